// File: doc/BRIEF.md
# Interrupt Priority and Vector Resolver

This block decides, every clock, which interrupt source a small 8-bit processor core should take next. It watches six non-maskable events (power-on/external reset, clock-monitor failure, watchdog timeout, illegal opcode, the active-low high-priority interrupt pin, and the software-interrupt instruction) together with fifteen maskable request lines. One of the maskable lines is the active-low general interrupt pin. That pin can be configured as level-sensitive or as falling-edge-sensitive. The core supplies its two condition-code mask bits, I and X, to the block.

The result is registered: a pending flag, the index of the winning source and the 16-bit address of that source's two-byte slot in the vector table at the top of the address space. Software can promote any one maskable source above all other maskable sources, but only while the I bit is set. The X mask is one-way: once it has been seen clear after reset, the high-priority pin can no longer be masked. The core pulses an acknowledge input when it takes the vector. This pulse consumes a latched edge request from the general pin.

Top module: `intr_resolver`

## Requirements
- R1: While rst_n is low and on the first cycle after it, pend_o is 0, idx_o is 0 and vec_o is 16'hFFFE. Whenever nothing wins, the outputs also read pend_o=0, idx_o=0, vec_o=16'hFFFE.
- R2: The source indices and their vectors are fixed. The vector of index k is 16'hFFFE minus 2*k. The indices are: reset 0, clock monitor 1, watchdog 2, illegal opcode 3, software interrupt 4, high-priority pin 5. Among non-maskable sources the priority runs reset, clock monitor, watchdog, illegal opcode, high-priority pin, software interrupt.
- R3: Every non-maskable source wins regardless of ccr_i and ranks above every maskable request.
- R4: While ccr_i=1 no maskable source wins. A held or latched maskable request is not lost, and it wins once ccr_i=0.
- R5: Maskable source m (0..14) has index 6+m. m=0 is the general pin, with vector 16'hFFF2. ext_req[k] is source m=k+1. Without promotion, the lowest m among active requests wins.
- R6: The high-priority pin (xirq_n, active low) is blocked while ccr_x=1. Once ccr_x has been sampled 0 after reset, later values of ccr_x=1 no longer block it.
- R7: With irq_edge_mode=0, the general pin requests while irq_n is low and stops requesting when irq_n is high.
- R8: With irq_edge_mode=1, a falling edge on irq_n is latched and stays requesting after irq_n returns high. It is cleared by ack sampled high while the block shows pend_o=1 and idx_o=6.
- R9: The promotion field (elev_data, 4 bits) selects maskable source m and ranks it above all other maskable sources. Its reset value is 0, which selects the general pin. The value 15 selects nothing, and the default order applies.
- R10: elev_wr updates the promotion field only while ccr_i=1. A write made while ccr_i=0 has no effect.
- R11: The outputs change only at a rising clock edge. An input change between edges leaves them unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_evt | input | 1 | Reset event request |
| clkmon_evt | input | 1 | Clock-monitor failure request |
| wdog_evt | input | 1 | Watchdog timeout request |
| illop_evt | input | 1 | Illegal-opcode request |
| swi_evt | input | 1 | Software-interrupt instruction request |
| xirq_n | input | 1 | High-priority interrupt pin, active low |
| irq_n | input | 1 | General interrupt pin, active low |
| irq_edge_mode | input | 1 | 1 = falling-edge mode for irq_n, 0 = level mode |
| ext_req | input | NUM_MASK-1 | Other maskable requests, active high |
| ccr_i | input | 1 | I mask bit from the condition code register |
| ccr_x | input | 1 | X mask bit from the condition code register |
| elev_wr | input | 1 | Write strobe for the promotion field |
| elev_data | input | SEL_W | Promotion field write data |
| ack | input | 1 | Vector taken by the core |
| pend_o | output | 1 | A source is being requested |
| idx_o | output | IDX_W | Index of the winning source |
| vec_o | output | 16 | Vector-table address of the winner |

## Verification
The bench builds the block with its default parameters: fifteen maskable sources, a 5-bit index and a 4-bit promotion field. With these values the whole non-maskable ladder, the promoted slot at the last maskable position and the "select nothing" code 15 can all be reached. Stimulus walks both the reset order and the order of the high-priority pin against the software interrupt. It also covers the one-way X lock, level and edge behaviour of the general pin under both I settings, and promotion writes made with the I bit clear and with it set.

// File: rtl/intr_pkg.sv
// Package: shared source indices and the vector-address rule for the
// interrupt resolver. Assumes a downward-growing table of 2-byte slots.
package intr_pkg;
    localparam int IDX_RESET  = 0;
    localparam int IDX_CLKMON = 1;
    localparam int IDX_WDOG   = 2;
    localparam int IDX_ILLOP  = 3;
    localparam int IDX_SWI    = 4;
    localparam int IDX_XIRQ   = 5;
    localparam int IDX_MASK0  = 6;   // first maskable slot (general pin)
    localparam int NMI_CNT    = 6;
endpackage

// File: rtl/intr_irq_cond.sv
// Module: conditions the active-low general interrupt pin.
// Level mode passes the pin through; edge mode latches a falling edge until
// cleared. Assumes irq_n is already synchronous to clk.
module intr_irq_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic edge_mode,
    input  logic clr,
    output logic irq_act
);
    logic irq_n_q;
    logic latch_q;
    logic fall;

    // Detect a high-to-low transition of the pin.
    assign fall = irq_n_q & ~irq_n;

    // Hold previous pin level and the edge latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n_q <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            irq_n_q <= irq_n;
            latch_q <= edge_mode & (fall | (latch_q & ~clr));
        end
    end

    // Present the request as seen this cycle, dropping a latch being cleared.
    always_comb begin
        if (edge_mode) irq_act = latch_q & ~clr;
        else           irq_act = ~irq_n;
    end
endmodule

// File: rtl/intr_elev_reg.sv
// Module: holds the maskable-promotion field. Loads only while the I mask is
// set; resets to 0 (general pin promoted).
module intr_elev_reg #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             i_bit,
    input  logic [SEL_W-1:0] data,
    output logic [SEL_W-1:0] sel_q
);
    // Accept writes only when maskable interrupts are blocked.
    always_ff @(posedge clk) begin
        if (!rst_n)          sel_q <= '0;
        else if (wr && i_bit) sel_q <= data;
    end
endmodule

// File: rtl/intr_prio_pick.sv
// Module: combinational priority choice. Fixed non-maskable ladder first,
// then the maskable set (gated by I) with one optional promoted member.
module intr_prio_pick
    import intr_pkg::*;
#(
    parameter int NUM_MASK = 15,
    parameter int IDX_W    = 5,
    parameter int SEL_W    = 4
) (
    input  logic                rst_evt,
    input  logic                clkmon_evt,
    input  logic                wdog_evt,
    input  logic                illop_evt,
    input  logic                xirq_act,
    input  logic                swi_evt,
    input  logic [NUM_MASK-1:0] mreq,
    input  logic                i_bit,
    input  logic [SEL_W-1:0]    sel,
    output logic                hit,
    output logic [IDX_W-1:0]    idx
);
    logic             mhit;
    logic             elev_hit;
    logic [IDX_W-1:0] midx;

    // Find the maskable winner: lowest active index unless the promoted one is active.
    always_comb begin
        mhit     = 1'b0;
        elev_hit = 1'b0;
        midx     = '0;
        for (int m = NUM_MASK - 1; m >= 0; m--) begin
            if (mreq[m]) begin
                mhit = 1'b1;
                midx = IDX_W'(m);
            end
        end
        for (int m = 0; m < NUM_MASK; m++) begin
            if (mreq[m] && (SEL_W'(m) == sel)) elev_hit = 1'b1;
        end
        if (elev_hit) midx = IDX_W'(sel);
    end

    // Walk the full ladder from the top.
    always_comb begin
        hit = 1'b1;
        idx = '0;
        if      (rst_evt)       idx = IDX_W'(IDX_RESET);
        else if (clkmon_evt)    idx = IDX_W'(IDX_CLKMON);
        else if (wdog_evt)      idx = IDX_W'(IDX_WDOG);
        else if (illop_evt)     idx = IDX_W'(IDX_ILLOP);
        else if (xirq_act)      idx = IDX_W'(IDX_XIRQ);
        else if (swi_evt)       idx = IDX_W'(IDX_SWI);
        else if (!i_bit && mhit) idx = IDX_W'(IDX_MASK0) + midx;
        else                    hit = 1'b0;
    end
endmodule

// File: rtl/intr_resolver.sv
// Module: top of the interrupt resolver. Conditions the general pin, keeps
// the one-way X lock and promotion field, picks a winner and registers the
// pending flag, index and vector address. Assumes synchronous inputs.
module intr_resolver
    import intr_pkg::*;
#(
    parameter int          NUM_MASK = 15,
    parameter logic [15:0] VEC_TOP  = 16'hFFFE,
    localparam int         IDX_W    = $clog2(NMI_CNT + NUM_MASK),
    localparam int         SEL_W    = $clog2(NUM_MASK + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_evt,
    input  logic                clkmon_evt,
    input  logic                wdog_evt,
    input  logic                illop_evt,
    input  logic                swi_evt,
    input  logic                xirq_n,
    input  logic                irq_n,
    input  logic                irq_edge_mode,
    input  logic [NUM_MASK-2:0] ext_req,
    input  logic                ccr_i,
    input  logic                ccr_x,
    input  logic                elev_wr,
    input  logic [SEL_W-1:0]    elev_data,
    input  logic                ack,
    output logic                pend_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic [15:0]         vec_o
);
    logic                irq_act;
    logic                irq_clr;
    logic                x_clr_q;
    logic                xirq_act;
    logic [SEL_W-1:0]    elev_q;
    logic [NUM_MASK-1:0] mreq;
    logic                hit_d;
    logic [IDX_W-1:0]    idx_d;
    logic [15:0]         vec_d;

    // Acknowledge consumes the general-pin latch only when it is the shown winner.
    assign irq_clr = ack & pend_o & (idx_o == IDX_W'(IDX_MASK0));

    intr_irq_cond u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_n     (irq_n),
        .edge_mode (irq_edge_mode),
        .clr       (irq_clr),
        .irq_act   (irq_act)
    );

    intr_elev_reg #(.SEL_W(SEL_W)) u_elev (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (elev_wr),
        .i_bit (ccr_i),
        .data  (elev_data),
        .sel_q (elev_q)
    );

    // Remember that X has been cleared; it can never mask again.
    always_ff @(posedge clk) begin
        if (!rst_n) x_clr_q <= 1'b0;
        else        x_clr_q <= x_clr_q | ~ccr_x;
    end

    // High-priority pin request after the effective X mask.
    assign xirq_act = ~xirq_n & ~(ccr_x & ~x_clr_q);

    // Maskable request vector: general pin in slot 0.
    assign mreq = {ext_req, irq_act};

    intr_prio_pick #(
        .NUM_MASK (NUM_MASK),
        .IDX_W    (IDX_W),
        .SEL_W    (SEL_W)
    ) u_pick (
        .rst_evt    (rst_evt),
        .clkmon_evt (clkmon_evt),
        .wdog_evt   (wdog_evt),
        .illop_evt  (illop_evt),
        .xirq_act   (xirq_act),
        .swi_evt    (swi_evt),
        .mreq       (mreq),
        .i_bit      (ccr_i),
        .sel        (elev_q),
        .hit        (hit_d),
        .idx        (idx_d)
    );

    // Slot address from the index.
    assign vec_d = VEC_TOP - (16'(idx_d) << 1);

    // Register the result so it is stable through each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            idx_o  <= '0;
            vec_o  <= VEC_TOP;
        end else begin
            pend_o <= hit_d;
            idx_o  <= idx_d;
            vec_o  <= vec_d;
        end
    end
endmodule

// File: rtl/intr_resolver_chk.sv
// Module: assertion checker for intr_resolver, attached by bind.
module intr_resolver_chk #(
    parameter int IDX_W = 5,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_evt,
    input logic             clkmon_evt,
    input logic             wdog_evt,
    input logic             illop_evt,
    input logic             swi_evt,
    input logic             ccr_i,
    input logic             ccr_x,
    input logic             pend_o,
    input logic [IDX_W-1:0] idx_o,
    input logic [15:0]      vec_o,
    input logic [SEL_W-1:0] elev_q,
    input logic             x_clr_q
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!pend_o && idx_o == '0 && vec_o == 16'hFFFE));

    // R2
    reset_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_evt)) |-> (idx_o == '0 && vec_o == 16'hFFFE));

    // R3
    nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(rst_evt) || $past(clkmon_evt) || $past(wdog_evt)
                          || $past(illop_evt) || $past(swi_evt)))
        |-> (pend_o && idx_o < IDX_W'(6)));

    // R4
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && idx_o >= IDX_W'(6)) |-> $past(!ccr_i));

    // R6
    x_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(x_clr_q)) |-> x_clr_q);

    // R6
    x_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ccr_x)) |-> x_clr_q);

    // R10
    elev_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ccr_i)) |-> $stable(elev_q));

    // R2
    vec_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_o == (16'hFFFE - (16'(idx_o) << 1)));
endmodule

bind intr_resolver intr_resolver_chk #(.IDX_W(IDX_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_evt    (rst_evt),
    .clkmon_evt (clkmon_evt),
    .wdog_evt   (wdog_evt),
    .illop_evt  (illop_evt),
    .swi_evt    (swi_evt),
    .ccr_i      (ccr_i),
    .ccr_x      (ccr_x),
    .pend_o     (pend_o),
    .idx_o      (idx_o),
    .vec_o      (vec_o),
    .elev_q     (elev_q),
    .x_clr_q    (x_clr_q)
);

// File: tb/sim_intr_resolver.sv
// Bench: scoreboard style. A driver task queues expected results; a monitor
// process compares them at the falling edge on which they fall due.
module sim_intr_resolver;
    localparam int NUM_MASK = 15;
    localparam int IDX_W    = 5;
    localparam int SEL_W    = 4;

    typedef struct {
        int          due;
        string       tag;
        logic        p;
        logic [4:0]  i;
        logic [15:0] v;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                rst_evt = 0, clkmon_evt = 0, wdog_evt = 0, illop_evt = 0, swi_evt = 0;
    logic                xirq_n = 1, irq_n = 1, irq_edge_mode = 0;
    logic [NUM_MASK-2:0] ext_req = '0;
    logic                ccr_i = 1, ccr_x = 1, elev_wr = 0, ack = 0;
    logic [SEL_W-1:0]    elev_data = '0;
    logic                pend_o;
    logic [IDX_W-1:0]    idx_o;
    logic [15:0]         vec_o;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    intr_resolver #(.NUM_MASK(NUM_MASK)) u0 (
        .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt), .clkmon_evt(clkmon_evt),
        .wdog_evt(wdog_evt), .illop_evt(illop_evt), .swi_evt(swi_evt),
        .xirq_n(xirq_n), .irq_n(irq_n), .irq_edge_mode(irq_edge_mode),
        .ext_req(ext_req), .ccr_i(ccr_i), .ccr_x(ccr_x), .elev_wr(elev_wr),
        .elev_data(elev_data), .ack(ack), .pend_o(pend_o), .idx_o(idx_o), .vec_o(vec_o)
    );

    always #5 clk = ~clk;

    // Count rising edges for due-time bookkeeping.
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] vaddr(int k);
        return 16'hFFFE - 16'(2 * k);
    endfunction

    task automatic compare(string tag, logic p, logic [4:0] i, logic [15:0] v);
        checks++;
        if (pend_o !== p || idx_o !== i || vec_o !== v) begin
            errors++;
            $display("FAIL %s: got pend=%0b idx=%0d vec=%h, expected pend=%0b idx=%0d vec=%h",
                     tag, pend_o, idx_o, vec_o, p, i, v);
        end
    endtask

    // Driver: queue an expectation two edges ahead and wait for it.
    task automatic expect_in2(string tag, logic p, int k);
        exp_t e;
        e.due = cyc + 2; e.tag = tag; e.p = p; e.i = 5'(k); e.v = vaddr(k);
        sb.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_elev(logic [SEL_W-1:0] d);
        elev_data = d; elev_wr = 1;
        @(negedge clk);
        elev_wr = 0;
    endtask

    // Monitor: pop and compare items that are due.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            compare(e.tag, e.p, e.i, e.v);
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in reset", 0, 0, 16'hFFFE);
        rst_n = 1;
        expect_in2("R1 after reset", 0, 0);

        ext_req[2] = 1;                      // m=3
        expect_in2("R4 masked by I", 0, 0);
        ccr_i = 0;
        expect_in2("R4 R5 m3 after unmask", 1, 9);
        ext_req[0] = 1;                      // m=1
        expect_in2("R5 lower m wins", 1, 7);
        irq_n = 0;
        expect_in2("R7 R5 level pin at FFF2", 1, 6);

        illop_evt = 1;
        expect_in2("R3 illegal over maskable", 1, 3);
        ccr_i = 1;
        expect_in2("R3 ignores I", 1, 3);
        swi_evt = 1;
        expect_in2("R2 illegal over swi", 1, 3);
        illop_evt = 0;
        expect_in2("R2 swi slot", 1, 4);
        wdog_evt = 1;
        expect_in2("R2 watchdog", 1, 2);
        clkmon_evt = 1;
        expect_in2("R2 clock monitor", 1, 1);
        rst_evt = 1;
        expect_in2("R2 reset event", 1, 0);
        rst_evt = 0; clkmon_evt = 0; wdog_evt = 0; swi_evt = 0;

        // R11: input change between edges leaves outputs alone.
        @(negedge clk);
        illop_evt = 1;
        #1 compare("R11 no change before edge", 0, 0, 16'hFFFE);
        illop_evt = 0;
        @(negedge clk);

        xirq_n = 0;
        expect_in2("R6 blocked by X", 0, 0);
        swi_evt = 1;
        expect_in2("R6 swi while X set", 1, 4);
        ccr_x = 0;
        expect_in2("R2 R6 pin over swi", 1, 5);
        swi_evt = 0; ccr_x = 1;
        expect_in2("R6 X lock one-way", 1, 5);
        xirq_n = 1;

        ccr_i = 0; irq_n = 1;
        expect_in2("R7 pin released", 1, 7);
        ext_req = '0;
        expect_in2("R4 nothing pending", 0, 0);

        pulse_elev(4'd3);                    // ccr_i=0: ignored
        ext_req[0] = 1; ext_req[2] = 1;
        expect_in2("R10 write ignored", 1, 7);
        ccr_i = 1;
        pulse_elev(4'd3);
        ccr_i = 0;
        expect_in2("R9 promoted m3", 1, 9);
        irq_n = 0;
        expect_in2("R9 promoted above pin", 1, 9);
        ccr_i = 1;
        pulse_elev(4'd15);
        ccr_i = 0;
        expect_in2("R9 code 15 default order", 1, 6);
        irq_n = 1; ext_req = '0; ccr_i = 1;
        pulse_elev(4'd0);

        irq_edge_mode = 1; ccr_i = 0;
        @(negedge clk);
        irq_n = 0;
        @(negedge clk);
        irq_n = 1;
        expect_in2("R8 edge latched", 1, 6);
        ack = 1;
        @(negedge clk);
        ack = 0;
        expect_in2("R8 cleared by ack", 0, 0);

        ccr_i = 1;
        irq_n = 0;
        @(negedge clk);
        irq_n = 1;
        expect_in2("R4 R8 latched under I", 0, 0);
        ccr_i = 0;
        expect_in2("R4 R8 latch survives mask", 1, 6);
        ack = 1;
        @(negedge clk);
        ack = 0;
        expect_in2("R8 second clear", 0, 0);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule